// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the general-purpose registers and the per-mode saved-status words of a processor core that switches between several privilege and exception modes. Sixteen architectural indices (0 to 15) are visible at any time. The current 5-bit mode code, presented on the `mode` input, picks which physical copy each index reaches. Indices 0 to 7 and index 15 always reach one shared copy. The fast-interrupt mode swaps in private copies of indices 8 to 14. The interrupt, supervisor, abort and undefined modes swap in private copies of indices 13 and 14 only. The user and system modes share the base copies.

The file offers two combinational read ports and one write port for the general registers. It also has one read/write port for the saved-status word of the current mode. An access to a saved status from a mode that has none raises an error flag in the same cycle. A user-bank override input sends every general-register access to the base copies while a privileged mode is active. Block transfers to and from the user registers use it.

Storage is 31 physical general registers and 5 saved-status words, all cleared by reset. There is no sequencing state. The mode decoder maps the mode code to one of six named banks: USR, FIQ, IRQ, SVC, ABT and UND. Three address mappers, one per port, translate each (bank, index) pair to a physical slot.

Top module: `banked_regfile`

## Requirements
- R1: After reset every physical general register and every saved-status word reads as zero, in every mode.
- R2: Indices 0 to 7 and index 15 reach the same physical register in every mode.
- R3: User mode (10000) and system mode (11111) reach the same copies of indices 0 to 14 and have no saved-status word.
- R4: Fast-interrupt mode (10001) has private copies of indices 8 to 14 and its own saved-status word. Its writes to those indices leave the user copies unchanged.
- R5: Interrupt (10010), supervisor (10011), abort (10111) and undefined (11011) modes each have private copies of indices 13 and 14 and their own saved-status word. They share indices 8 to 12 with user mode.
- R6: Both read ports return the addressed register combinationally. A write takes effect at the next rising clock edge, so a read of the index written in the same cycle returns the previous value.
- R7: A saved-status access (read or write enable) in a mode with no saved-status word drives `ss_err` high in that same cycle. `ss_rd_data` reads zero and the write is discarded.
- R8: While `user_bank` is high, both read ports and the write port reach the user copies, whatever the mode. The saved-status port still follows `mode`.
- R9: Any mode code outside the seven listed is treated like user mode: user copies, no saved-status word, and `ss_err` on a saved-status access.
- R10: `ss_err` is low in any cycle with neither saved-status enable high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 5 | Current processor mode code |
| user_bank | input | 1 | Route general-register accesses to the user copies |
| rd_a_idx | input | 4 | Read port A architectural index |
| rd_a_data | output | DATA_W | Read port A data |
| rd_b_idx | input | 4 | Read port B architectural index |
| rd_b_data | output | DATA_W | Read port B data |
| wr_en | input | 1 | General-register write enable |
| wr_idx | input | 4 | Write architectural index |
| wr_data | input | DATA_W | Write data |
| ss_rd_en | input | 1 | Saved-status read enable |
| ss_rd_data | output | SS_W | Saved-status word of the current mode, zero if the mode has none |
| ss_wr_en | input | 1 | Saved-status write enable |
| ss_wr_data | input | SS_W | Saved-status write data |
| ss_err | output | 1 | Saved-status access in a mode without one |

## Verification
The read data, `ss_rd_data` and `ss_err` depend combinationally on the inputs of the current cycle. The bench therefore drives each input set on the falling edge and samples these outputs a short delay later, within the same cycle. A write becomes visible only after the next rising edge. The bench's reference model absorbs each write only after that edge, so a read of an index written in the same cycle is compared with the old value. Every random and directed cycle compares both read ports, the error flag and the saved-status data against that model.

// File: rtl/bankrf_pkg.sv
package bankrf_pkg;

    localparam int NUM_ARCH  = 16;
    localparam int IDX_W     = $clog2(NUM_ARCH);
    localparam int MODE_W    = 5;

    // banked index windows
    localparam int FIQ_LO    = 8;
    localparam int BANK_HI   = 14;
    localparam int EXC_LO    = 13;
    localparam int FIQ_CNT   = BANK_HI - FIQ_LO + 1;
    localparam int EXC_CNT   = BANK_HI - EXC_LO + 1;
    localparam int NUM_EXC   = 4;

    localparam int FIQ_BASE  = NUM_ARCH;
    localparam int EXC_BASE  = FIQ_BASE + FIQ_CNT;
    localparam int NUM_PHYS  = EXC_BASE + NUM_EXC * EXC_CNT;
    localparam int PHYS_W    = $clog2(NUM_PHYS);

    localparam int NUM_SS    = 1 + NUM_EXC;
    localparam int SLOT_W    = $clog2(NUM_SS);

    localparam logic [MODE_W-1:0] MD_USR = 5'b10000;
    localparam logic [MODE_W-1:0] MD_FIQ = 5'b10001;
    localparam logic [MODE_W-1:0] MD_IRQ = 5'b10010;
    localparam logic [MODE_W-1:0] MD_SVC = 5'b10011;
    localparam logic [MODE_W-1:0] MD_ABT = 5'b10111;
    localparam logic [MODE_W-1:0] MD_UND = 5'b11011;
    localparam logic [MODE_W-1:0] MD_SYS = 5'b11111;

    typedef enum logic [2:0] {
        BK_USR = 3'd0,
        BK_FIQ = 3'd1,
        BK_IRQ = 3'd2,
        BK_SVC = 3'd3,
        BK_ABT = 3'd4,
        BK_UND = 3'd5
    } bank_e;

endpackage

// File: rtl/bankrf_mode_dec.sv
module bankrf_mode_dec
    import bankrf_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    input  logic              user_bank,
    output bank_e             gp_bank,
    output bank_e             ss_bank,
    output logic              ss_valid
);

    bank_e raw_bank;

    always_comb begin
        unique case (mode)
            MD_FIQ:  raw_bank = BK_FIQ;
            MD_IRQ:  raw_bank = BK_IRQ;
            MD_SVC:  raw_bank = BK_SVC;
            MD_ABT:  raw_bank = BK_ABT;
            MD_UND:  raw_bank = BK_UND;
            default: raw_bank = BK_USR;   // user, system and unlisted codes
        endcase
    end

    always_comb begin
        ss_bank  = raw_bank;
        ss_valid = (raw_bank != BK_USR);
        gp_bank  = user_bank ? BK_USR : raw_bank;
    end

endmodule

// File: rtl/bankrf_map.sv
module bankrf_map
    import bankrf_pkg::*;
(
    input  bank_e             bank,
    input  logic [IDX_W-1:0]  idx,
    output logic [PHYS_W-1:0] phys
);

    int idx_i;
    int exc_ord;
    logic in_fiq_win;
    logic in_exc_win;
    logic is_exc_bank;

    always_comb begin
        idx_i       = int'(idx);
        exc_ord     = int'(bank) - int'(BK_IRQ);
        in_fiq_win  = (idx_i >= FIQ_LO) && (idx_i <= BANK_HI);
        in_exc_win  = (idx_i >= EXC_LO) && (idx_i <= BANK_HI);
        is_exc_bank = (bank == BK_IRQ) || (bank == BK_SVC) ||
                      (bank == BK_ABT) || (bank == BK_UND);

        phys = PHYS_W'(idx_i);
        if ((bank == BK_FIQ) && in_fiq_win) begin
            phys = PHYS_W'(FIQ_BASE + idx_i - FIQ_LO);
        end else if (is_exc_bank && in_exc_win) begin
            phys = PHYS_W'(EXC_BASE + exc_ord * EXC_CNT + idx_i - EXC_LO);
        end
    end

endmodule

// File: rtl/bankrf_gpr.sv
module bankrf_gpr
    import bankrf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PHYS_W-1:0] rd_a_phys,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [PHYS_W-1:0] rd_b_phys,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [PHYS_W-1:0] wr_phys,
    input  logic [DATA_W-1:0] wr_data
);

    logic [NUM_PHYS-1:0][DATA_W-1:0] q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (wr_en) begin
            q[wr_phys] <= wr_data;
        end
    end

    always_comb begin
        rd_a_data = q[rd_a_phys];
        rd_b_data = q[rd_b_phys];
    end

    // R6: a write is visible from the next cycle on
    p_wr_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> q[$past(wr_phys)] == $past(wr_data));

    // R6: no write, no change in storage
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(q));

endmodule

// File: rtl/bankrf_ss.sv
module bankrf_ss
    import bankrf_pkg::*;
#(
    parameter int SS_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  bank_e           ss_bank,
    input  logic            ss_valid,
    input  logic            rd_en,
    input  logic            wr_en,
    input  logic [SS_W-1:0] wr_data,
    output logic [SS_W-1:0] rd_data,
    output logic            err
);

    logic [NUM_SS-1:0][SS_W-1:0] q;
    logic [SLOT_W-1:0]           slot;

    always_comb begin
        slot    = ss_valid ? SLOT_W'(int'(ss_bank) - 1) : '0;
        rd_data = ss_valid ? q[slot] : '0;
        err     = (rd_en || wr_en) && !ss_valid;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (wr_en && ss_valid) begin
            q[slot] <= wr_data;
        end
    end

    // R7: a faulting access alters no saved-status word
    p_err_discard_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> $stable(q));

    // R7: a faulting access reads zero
    p_err_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> rd_data == '0);

    // R10: no enable, no error
    p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en && !wr_en) |-> !err);

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import bankrf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SS_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        mode,
    input  logic              user_bank,
    input  logic [3:0]        rd_a_idx,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [3:0]        rd_b_idx,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [3:0]        wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ss_rd_en,
    output logic [SS_W-1:0]   ss_rd_data,
    input  logic              ss_wr_en,
    input  logic [SS_W-1:0]   ss_wr_data,
    output logic              ss_err
);

    localparam int NUM_PORTS = 3;   // read A, read B, write

    bank_e gp_bank;
    bank_e ss_bank;
    logic  ss_valid;

    logic [IDX_W-1:0]  port_idx  [NUM_PORTS];
    logic [PHYS_W-1:0] port_phys [NUM_PORTS];

    always_comb begin
        port_idx[0] = rd_a_idx;
        port_idx[1] = rd_b_idx;
        port_idx[2] = wr_idx;
    end

    bankrf_mode_dec u_dec (
        .mode      (mode),
        .user_bank (user_bank),
        .gp_bank   (gp_bank),
        .ss_bank   (ss_bank),
        .ss_valid  (ss_valid)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_map
        bankrf_map u_map (
            .bank (gp_bank),
            .idx  (port_idx[p]),
            .phys (port_phys[p])
        );
    end

    bankrf_gpr #(.DATA_W(DATA_W)) u_gpr (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_a_phys (port_phys[0]),
        .rd_a_data (rd_a_data),
        .rd_b_phys (port_phys[1]),
        .rd_b_data (rd_b_data),
        .wr_en     (wr_en),
        .wr_phys   (port_phys[2]),
        .wr_data   (wr_data)
    );

    bankrf_ss #(.SS_W(SS_W)) u_ss (
        .clk      (clk),
        .rst_n    (rst_n),
        .ss_bank  (ss_bank),
        .ss_valid (ss_valid),
        .rd_en    (ss_rd_en),
        .wr_en    (ss_wr_en),
        .wr_data  (ss_wr_data),
        .rd_data  (ss_rd_data),
        .err      (ss_err)
    );

    // R2: shared indices map to themselves in every mode
    p_shared_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_idx < 4'd8 || rd_a_idx == 4'd15) |-> port_phys[0] == PHYS_W'(rd_a_idx));

    // R2: every mapped slot exists
    p_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        int'(port_phys[1]) < NUM_PHYS);

    // R4: fast-interrupt writes to 8..14 stay in the private window
    p_fiq_win_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_FIQ && !user_bank && wr_idx >= 4'd8 && wr_idx <= 4'd14)
        |-> (int'(port_phys[2]) >= FIQ_BASE && int'(port_phys[2]) < EXC_BASE));

    // R8: override sends the write to the user copy
    p_override_r8: assert property (@(posedge clk) disable iff (!rst_n)
        user_bank |-> port_phys[2] == PHYS_W'(wr_idx));

endmodule

// File: tb/banked_regfile_tb.sv
`timescale 1ns/1ps
module banked_regfile_tb_top;

    localparam int DW = 32;
    localparam int SW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [4:0]    mode = 5'b10000;
    logic          user_bank = 1'b0;
    logic [3:0]    rd_a_idx = '0;
    logic [DW-1:0] rd_a_data;
    logic [3:0]    rd_b_idx = '0;
    logic [DW-1:0] rd_b_data;
    logic          wr_en = 1'b0;
    logic [3:0]    wr_idx = '0;
    logic [DW-1:0] wr_data = '0;
    logic          ss_rd_en = 1'b0;
    logic [SW-1:0] ss_rd_data;
    logic          ss_wr_en = 1'b0;
    logic [SW-1:0] ss_wr_data = '0;
    logic          ss_err;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    logic [DW-1:0] mdl  [0:5][0:15];
    logic [SW-1:0] smdl [0:5];

    always #10 clk = ~clk;   // 50 MHz

    banked_regfile #(.DATA_W(DW), .SS_W(SW)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode(mode), .user_bank(user_bank),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .ss_rd_en(ss_rd_en), .ss_rd_data(ss_rd_data),
        .ss_wr_en(ss_wr_en), .ss_wr_data(ss_wr_data), .ss_err(ss_err)
    );

    // bank numbers: 0 user/system/unlisted, 1 fiq, 2 irq, 3 svc, 4 abt, 5 und
    function automatic int bank_of(logic [4:0] m);
        case (m)
            5'b10001: return 1;
            5'b10010: return 2;
            5'b10011: return 3;
            5'b10111: return 4;
            5'b11011: return 5;
            default:  return 0;
        endcase
    endfunction

    function automatic int owner(int bk, int idx, bit ovr);
        if (ovr) return 0;
        if (bk == 1 && idx >= 8 && idx <= 14) return 1;
        if (bk >= 2 && (idx == 13 || idx == 14)) return bk;
        return 0;
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // drive on the falling edge, check combinational outputs, then retire the edge
    task automatic cyc(string tag, logic [4:0] m, bit ovr, int ra, int rb,
                       bit we, int wi, logic [DW-1:0] wd,
                       bit sre, bit swe, logic [SW-1:0] swd);
        int bk;
        bk = bank_of(m);
        mode = m; user_bank = ovr;
        rd_a_idx = 4'(ra); rd_b_idx = 4'(rb);
        wr_en = we; wr_idx = 4'(wi); wr_data = wd;
        ss_rd_en = sre; ss_wr_en = swe; ss_wr_data = swd;
        #2;
        chk({tag, " rd_a"}, 64'(rd_a_data), 64'(mdl[owner(bk, ra, ovr)][ra]));
        chk({tag, " rd_b"}, 64'(rd_b_data), 64'(mdl[owner(bk, rb, ovr)][rb]));
        chk({tag, " ss_err"}, 64'(ss_err), 64'((sre || swe) && bk == 0));
        chk({tag, " ss_rd"}, 64'(ss_rd_data), 64'((bk == 0) ? '0 : smdl[bk]));
        @(posedge clk);
        if (we) mdl[owner(bk, wi, ovr)][wi] = wd;
        if (swe && bk != 0) smdl[bk] = swd;
        @(negedge clk);
    endtask

    localparam logic [4:0] MODES [0:8] = '{5'b10000, 5'b10001, 5'b10010, 5'b10011,
                                           5'b10111, 5'b11011, 5'b11111, 5'b00000, 5'b10100};

    initial begin
        #(20 * 200000);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        for (int b = 0; b < 6; b++) begin
            smdl[b] = '0;
            for (int i = 0; i < 16; i++) mdl[b][i] = '0;
        end
        void'($urandom(32'h5eed_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: everything zero after reset, every mode
        for (int mi = 0; mi < 7; mi++)
            for (int i = 0; i < 16; i += 2)
                cyc("R1", MODES[mi], 0, i, i + 1, 0, 0, '0, 1'b0, 0, '0);

        // R3: user write of 13 seen by system
        cyc("R3", 5'b10000, 0, 0, 0, 1, 13, 32'hA13A_0013, 0, 0, '0);
        cyc("R3", 5'b11111, 0, 13, 14, 0, 0, '0, 0, 0, '0);
        // R5: irq has its own 13, shares 12
        cyc("R5", 5'b10000, 0, 0, 0, 1, 12, 32'hB12B_0012, 0, 0, '0);
        cyc("R5", 5'b10010, 0, 13, 12, 1, 14, 32'h1414_0002, 0, 0, '0);
        cyc("R5", 5'b10011, 0, 14, 12, 0, 0, '0, 0, 0, '0);
        // R4: fiq owns 8..14
        cyc("R4", 5'b10001, 0, 12, 13, 1, 9, 32'hF9F9_0001, 0, 0, '0);
        cyc("R4", 5'b10000, 0, 9, 12, 0, 0, '0, 0, 0, '0);
        cyc("R4", 5'b10001, 0, 9, 8, 0, 0, '0, 0, 0, '0);
        // R2: shared low registers and index 15
        cyc("R2", 5'b10011, 0, 0, 0, 1, 3, 32'h0303_0303, 0, 0, '0);
        cyc("R2", 5'b10001, 0, 0, 0, 1, 15, 32'h1515_1515, 0, 0, '0);
        cyc("R2", 5'b11011, 0, 3, 15, 0, 0, '0, 0, 0, '0);
        // R6: same-cycle read returns old value, then new
        cyc("R6", 5'b10000, 0, 5, 5, 1, 5, 32'hC0DE_0005, 0, 0, '0);
        cyc("R6", 5'b10000, 0, 5, 5, 0, 0, '0, 0, 0, '0);
        // saved status: write in fiq and abt, then faulting accesses
        cyc("R4", 5'b10001, 0, 0, 0, 0, 0, '0, 1, 1, 32'h5A5A_0001);
        cyc("R5", 5'b10111, 0, 0, 0, 0, 0, '0, 1, 1, 32'h5A5A_0004);
        cyc("R7", 5'b10000, 0, 0, 0, 0, 0, '0, 1, 1, 32'hDEAD_BEEF);
        cyc("R7", 5'b11111, 0, 0, 0, 0, 0, '0, 0, 1, 32'hDEAD_BEEF);
        cyc("R7", 5'b10001, 0, 0, 0, 0, 0, '0, 1, 0, '0);
        cyc("R7", 5'b10111, 0, 0, 0, 0, 0, '0, 1, 0, '0);
        cyc("R10", 5'b10000, 0, 0, 0, 0, 0, '0, 0, 0, '0);
        // R8: override from irq writes and reads the user copy
        cyc("R8", 5'b10010, 1, 13, 14, 1, 13, 32'h0E0E_0013, 1, 0, '0);
        cyc("R8", 5'b10000, 0, 13, 0, 0, 0, '0, 0, 0, '0);
        cyc("R8", 5'b10010, 0, 13, 0, 0, 0, '0, 0, 0, '0);
        cyc("R8", 5'b10001, 1, 9, 13, 0, 0, '0, 0, 0, '0);
        // R9: unlisted codes behave like user mode
        cyc("R9", 5'b00000, 0, 13, 9, 1, 14, 32'h0909_0014, 1, 1, 32'h1111_1111);
        cyc("R9", 5'b10100, 0, 14, 13, 0, 0, '0, 1, 0, '0);
        cyc("R9", 5'b10000, 0, 14, 0, 0, 0, '0, 0, 0, '0);

        // random traffic against the model
        for (int n = 0; n < 3000; n++) begin
            logic [4:0] m;
            m = MODES[$urandom_range(0, 8)];
            cyc("R6", m, ($urandom_range(0, 7) == 0),
                $urandom_range(0, 15), $urandom_range(0, 15),
                $urandom_range(0, 1) == 1, $urandom_range(0, 15), $urandom(),
                $urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0, $urandom());
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule